// File: doc/BRIEF.md
# Serial Receiver with Extended Error Flags

This block receives asynchronous serial frames off a single input line and turns them into parallel data. A frame has a low start bit, data bits least significant first, and a high stop bit. The frame holds either eight data bits or nine. Timing comes from an external oversample tick that pulses `OVS` times per bit period. The receiver checks the start bit at its midpoint and samples every later bit at the midpoint of its period.

The block has three error flags that stay set once raised:
- **Framing error** is set when a frame ends with a low stop bit, in either frame length.
- **Break** is set when the line stays low for longer than the longest possible frame.
- **Overwrite** is set in extended mode when a completed byte replaces one that has not yet been taken.

With extended mode off, the receiver behaves conservatively. It refuses a new frame while the previous one is still flagged complete. In eight-bit mode it can also be told to drop any frame whose stop bit is low.

Top module: `uart_rx_ext`

## Requirements
- R1: In eight-bit mode (`mode9_i`=0) a frame is low start, 8 data bits LSB first, then stop. At the stop-bit midpoint `data_o` takes the byte and `done_o` goes to 1.
- R2: In nine-bit mode (`mode9_i`=1, sampled at the start bit) nine data bits are received. `data_o` holds bits 0..7 and `bit9_o` holds bit 8.
- R3: In eight-bit mode `bit9_o` takes the value sampled in the stop position.
- R4: `fe_o` is set whenever the stop position samples low, in either mode. It stays set until `err_clr_i`.
- R5: With `strict_i`=1, `ext_en_i`=0 and eight-bit mode, a frame with a low stop leaves `done_o`, `data_o` and `bit9_o` unchanged.
- R6: With `ext_en_i`=0 and `done_o`=1, a new frame leaves `data_o` and `bit9_o` unchanged and does not set `ovw_o`.
- R7: With `ext_en_i`=1 a frame is always accepted. If `done_o` was already 1, `data_o` is replaced and `ovw_o` is set.
- R8: A `buf_rd_i` pulse clears `ovw_o`.
- R9: A falling edge is taken as a start only if the line is still low half a bit period later. Otherwise the receiver returns to idle and no frame completes.
- R10: `be_o` is set once the line has been low for 12 bit periods (`12*OVS` ticks), which is longer than a full nine-bit frame. A nine-bit all-zero frame with a low stop does not set it. It stays set until `err_clr_i`.
- R11: With `ext_en_i`=1 a break also sets `fe_o`. With `ext_en_i`=0 it does not.
- R12: After reset all outputs are 0. `done_clr_i` clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick, OVS per bit period |
| rx_i | input | 1 | Serial line, already synchronized |
| mode9_i | input | 1 | 1 selects nine data bits |
| ext_en_i | input | 1 | Extended mode enable |
| strict_i | input | 1 | Drop eight-bit frames with a low stop |
| done_clr_i | input | 1 | Clears the receive-complete flag |
| err_clr_i | input | 1 | Clears the framing and break flags |
| buf_rd_i | input | 1 | Buffer read strobe; clears overwrite |
| data_o | output | DATA_W | Received byte |
| bit9_o | output | 1 | Ninth data bit, or the latched stop bit |
| done_o | output | 1 | Receive complete |
| fe_o | output | 1 | Framing error, sticky |
| be_o | output | 1 | Break error, sticky |
| ovw_o | output | 1 | Overwrite error, sticky |

## Verification
The bench builds the block with `OVS`=4, `DATA_W`=8 and a tick on every clock. This keeps a bit period at four cycles and puts the break threshold at 48 low ticks. A nine-bit all-zero frame is then only four ticks short of the threshold, so the "not a break" case and the break case sit close together. The short window also makes it possible to clear the framing flag in the gap between the end of the frame and the break, which separates a framing error raised by the break itself (extended mode) from one raised by the low stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/uart_rx_bitfsm.sv
module uart_rx_bitfsm
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              mode9_i,
  output logic              frm_end_o,
  output logic [DATA_W:0]   frm_bits_o,
  output logic              frm_stop_o,
  output logic              frm_mode9_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int BIT_W = $clog2(DATA_W + 2);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W:0]   sh;
  logic              line_q;
  logic              mode_q;
  logic [BIT_W-1:0]  last_bit;

  assign last_bit = mode_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      line_q  <= 1'b1;
      mode_q  <= 1'b0;
    end else if (tick_i) begin
      line_q <= rx_i;
      unique case (state)
        ST_IDLE: if (line_q && !rx_i) begin  // falling edge only
          state   <= ST_START;
          cnt     <= '0;
          bit_cnt <= '0;
          mode_q  <= mode9_i;
        end
        ST_START: if (cnt == CNT_W'(HALF - 1)) begin
          state <= rx_i ? ST_IDLE : ST_DATA;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_DATA: if (cnt == CNT_W'(OVS - 1)) begin
          cnt     <= '0;
          sh      <= {rx_i, sh[DATA_W:1]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == last_bit) state <= ST_STOP;
        end else cnt <= cnt + 1'b1;
        ST_STOP: if (cnt == CNT_W'(OVS - 1)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frm_end_o   = tick_i && (state == ST_STOP) && (cnt == CNT_W'(OVS - 1));
  assign frm_stop_o  = rx_i;
  assign frm_mode9_o = mode_q;
  assign frm_bits_o  = mode_q ? sh : {1'b0, sh[DATA_W:1]};

  // R9: a start that is high at its midpoint is dropped
  a_r9_glitch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_START && tick_i && cnt == CNT_W'(HALF - 1) && rx_i) |=> state == ST_IDLE);
  a_r1_end_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_end_o |=> state == ST_IDLE);
endmodule

// File: rtl/uart_rx_brkmon.sv
module uart_rx_brkmon #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic brk_o
);
  // longest frame is DATA_W+3 bits; one more bit period on top
  localparam int BRK_TICKS = (DATA_W + 4) * OVS;
  localparam int CW        = $clog2(BRK_TICKS + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (tick_i) begin
      if (rx_i) low_cnt <= '0;
      else if (low_cnt != CW'(BRK_TICKS)) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign brk_o = tick_i && !rx_i && (low_cnt == CW'(BRK_TICKS - 1));

  a_r10_brk_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o || !tick_i);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_en_i,
  input  logic              strict_i,
  input  logic              done_clr_i,
  input  logic              err_clr_i,
  input  logic              buf_rd_i,
  input  logic              frm_end_i,
  input  logic [DATA_W:0]   frm_bits_i,
  input  logic              frm_stop_i,
  input  logic              frm_mode9_i,
  input  logic              brk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              fe_o,
  output logic              be_o,
  output logic              ovw_o
);
  logic drop, take;

  assign drop = !frm_mode9_i && strict_i && !ext_en_i && !frm_stop_i;
  assign take = frm_end_i && (ext_en_i || !done_o) && !drop;

  // sets win over clears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      done_o <= 1'b0;
      fe_o   <= 1'b0;
      be_o   <= 1'b0;
      ovw_o  <= 1'b0;
    end else begin
      if (done_clr_i) done_o <= 1'b0;
      if (err_clr_i) begin
        fe_o <= 1'b0;
        be_o <= 1'b0;
      end
      if (buf_rd_i) ovw_o <= 1'b0;
      if (take) begin
        data_o <= frm_bits_i[DATA_W-1:0];
        bit9_o <= frm_mode9_i ? frm_bits_i[DATA_W] : frm_stop_i;
        done_o <= 1'b1;
        if (done_o) ovw_o <= 1'b1;
      end
      if (frm_end_i && !frm_stop_i) fe_o <= 1'b1;
      if (brk_i) begin
        be_o <= 1'b1;
        if (ext_en_i) fe_o <= 1'b1;
      end
    end
  end

  a_r7_ovw_needs_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovw_o) |-> $past(ext_en_i));
  a_r6_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ext_en_i) |=> $stable(data_o) && $stable(bit9_o));
  a_r5_strict_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_i && drop && !done_clr_i) |=> $stable(done_o) && $stable(data_o));
  a_r4_fe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_o) |-> $past(frm_end_i && !frm_stop_i || brk_i && ext_en_i));
endmodule

// File: rtl/uart_rx_ext.sv
module uart_rx_ext #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              mode9_i,
  input  logic              ext_en_i,
  input  logic              strict_i,
  input  logic              done_clr_i,
  input  logic              err_clr_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              fe_o,
  output logic              be_o,
  output logic              ovw_o
);
  logic            frm_end, frm_stop, frm_mode9, brk;
  logic [DATA_W:0] frm_bits;

  uart_rx_bitfsm #(.OVS(OVS), .DATA_W(DATA_W)) i_bitfsm (
    .clk_i, .rst_ni, .tick_i, .rx_i, .mode9_i,
    .frm_end_o(frm_end), .frm_bits_o(frm_bits),
    .frm_stop_o(frm_stop), .frm_mode9_o(frm_mode9)
  );

  uart_rx_brkmon #(.OVS(OVS), .DATA_W(DATA_W)) i_brkmon (
    .clk_i, .rst_ni, .tick_i, .rx_i, .brk_o(brk)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i, .rst_ni, .ext_en_i, .strict_i, .done_clr_i, .err_clr_i, .buf_rd_i,
    .frm_end_i(frm_end), .frm_bits_i(frm_bits), .frm_stop_i(frm_stop),
    .frm_mode9_i(frm_mode9), .brk_i(brk),
    .data_o, .bit9_o, .done_o, .fe_o, .be_o, .ovw_o
  );

  a_r10_break_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(be_o) |-> $past(!rx_i));
  a_r8_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_i && !frm_end) |=> !ovw_o);
endmodule

// File: tb/test_uart_rx_ext.sv
module test_uart_rx_ext;
  localparam int CLK_P  = 10;
  localparam int OVS    = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b1, rx_i = 1'b1, mode9_i = 1'b0, ext_en_i = 1'b0, strict_i = 1'b0;
  logic done_clr_i = 1'b0, err_clr_i = 1'b0, buf_rd_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic bit9_o, done_o, fe_o, be_o, ovw_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_ext #(.OVS(OVS), .DATA_W(DATA_W)) i_uart_rx_ext (
    .clk_i(clk), .rst_ni, .tick_i, .rx_i, .mode9_i, .ext_en_i, .strict_i,
    .done_clr_i, .err_clr_i, .buf_rd_i,
    .data_o, .bit9_o, .done_o, .fe_o, .be_o, .ovw_o
  );

  function automatic logic exp_b9(logic m9, logic [8:0] bits, logic stop);
    return m9 ? bits[8] : stop;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    rx_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [8:0] bits, logic m9, logic stop);
    hold(1'b0, OVS);
    for (int i = 0; i < (m9 ? 9 : 8); i++) hold(bits[i], OVS);
    hold(stop, OVS);
    hold(1'b1, 2*OVS);
  endtask

  task automatic clr_done();
    done_clr_i = 1'b1; @(negedge clk); done_clr_i = 1'b0; @(negedge clk);
  endtask
  task automatic clr_err();
    err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0; @(negedge clk);
  endtask
  task automatic rd_buf();
    buf_rd_i = 1'b1; @(negedge clk); buf_rd_i = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] bits;
    logic m9;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 reset done", done_o, 0);
    chk("R12 reset data", data_o, 0);
    chk("R12 reset flags", {fe_o, be_o, ovw_o, bit9_o}, 0);

    // R1 R2 R3 random good frames
    for (int k = 0; k < 8; k++) begin
      m9 = 1'($urandom % 2);
      bits = 9'($urandom);
      mode9_i = m9;
      send(bits, m9, 1'b1);
      chk(m9 ? "R2 data" : "R1 data", data_o, bits[7:0]);
      chk(m9 ? "R2 bit9" : "R3 bit9", bit9_o, exp_b9(m9, bits, 1'b1));
      chk("R1 done", done_o, 1);
      chk("R4 no fe", fe_o, 0);
      clr_done();
      chk("R12 done clr", done_o, 0);
    end

    // R4 R3 low stop, eight-bit
    mode9_i = 1'b0;
    send(9'h0A5, 1'b0, 1'b0);
    chk("R4 fe 8bit", fe_o, 1);
    chk("R3 stop latched", bit9_o, 0);
    chk("R4 data kept", data_o, 8'hA5);
    clr_done();
    send(9'h05A, 1'b0, 1'b1);
    chk("R4 fe sticky", fe_o, 1);
    clr_err(); clr_done();
    chk("R4 fe cleared", fe_o, 0);

    // R4 nine-bit low stop
    mode9_i = 1'b1;
    send(9'h1C3, 1'b1, 1'b0);
    chk("R4 fe 9bit", fe_o, 1);
    chk("R2 bit9 9bit", bit9_o, 1);
    chk("R2 data 9bit", data_o, 8'hC3);
    clr_err(); clr_done();

    // R5 strict drop
    mode9_i = 1'b0; strict_i = 1'b1;
    send(9'h03C, 1'b0, 1'b0);
    chk("R5 no done", done_o, 0);
    chk("R5 data unchanged", data_o, 8'hC3);
    chk("R4 fe strict", fe_o, 1);
    send(9'h03C, 1'b0, 1'b1);
    chk("R5 good accepted", data_o, 8'h3C);
    strict_i = 1'b0;
    clr_err();

    // R6 blocked while done
    send(9'h077, 1'b0, 1'b1);
    chk("R6 data held", data_o, 8'h3C);
    chk("R6 no ovw", ovw_o, 0);
    chk("R6 done", done_o, 1);

    // R7 R8 extended overwrite
    ext_en_i = 1'b1;
    send(9'h099, 1'b0, 1'b1);
    chk("R7 overwritten", data_o, 8'h99);
    chk("R7 ovw set", ovw_o, 1);
    rd_buf();
    chk("R8 ovw cleared", ovw_o, 0);
    chk("R8 done kept", done_o, 1);
    clr_done();
    ext_en_i = 1'b0;

    // R9 start glitch
    hold(1'b0, 1);
    hold(1'b1, 4*OVS);
    chk("R9 glitch no done", done_o, 0);
    bits = 9'($urandom);
    send(bits, 1'b0, 1'b1);
    chk("R9 after glitch", data_o, bits[7:0]);
    clr_done();

    // R10 all-zero nine-bit frame is not a break
    mode9_i = 1'b1;
    send(9'h000, 1'b1, 1'b0);
    chk("R10 no break", be_o, 0);
    chk("R4 fe zero frame", fe_o, 1);
    clr_err(); clr_done();

    // R10 R11 break, extended off then on
    for (int e = 0; e < 2; e++) begin
      ext_en_i = e[0];
      hold(1'b0, 11*OVS);
      err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0; @(negedge clk);
      hold(1'b0, 3*OVS);
      chk("R10 break set", be_o, 1);
      chk("R11 fe by break", fe_o, e[0]);
      hold(1'b1, 2*OVS);
      chk("R10 break sticky", be_o, 1);
      clr_err(); clr_done(); rd_buf();
      chk("R10 break cleared", be_o, 0);
    end
    ext_en_i = 1'b0;
    mode9_i = 1'b0;
    bits = 9'($urandom);
    send(bits, 1'b0, 1'b1);
    chk("R1 after break", data_o, bits[7:0]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule